// File: doc/BRIEF.md
# Error-Correcting Memory Controller Register Block

This block holds the software-visible control and status state of an error-correcting DRAM controller. A 32-bit register port reaches nine word registers: enable, timing delay, fault status, video setup, two fault address words, diagnostic, and two event counters. A build-time parameter picks one of three silicon variants. The variant sets the write mask of the enable register and the identity code placed in its top bits. It also sets which enable fields live through a soft reset, and whether a four-byte diagnostic window exists.

The error checker elsewhere in the controller reports each fault with a one-cycle capture pulse. The pulse carries a status word and two address words. The block latches them and raises a level interrupt, which software lowers by writing the fault status register. Two resets are used. Power-on reset loads every register with its initial value, including the variant code. The synchronous soft reset clears most registers but keeps selected enable-register configuration fields.

Top module: `mc_csr_top`

## Requirements
- R1: The register index is byte address bits [ADDR_W-1:2]. Indices 0..8 are enable, delay, fault status, video, fault address 0, fault address 1, diagnostic, event 0 and event 1. Indices 9 and above read as zero, and writes to them change nothing.
- R2: The register window accepts only word accesses (busSize = 2; 0 is byte, 1 is half, 3 is reserved). Any other size writes nothing and reads zero.
- R3: An enable-register write stores wdata & 0x00000103 in variant 0. In variants 1 and 2 it stores (wdata & 0x00000BFF) with the variant number forced into bits 31:28.
- R4: A delay-register write stores wdata & 0x7FFFFFFF, so bit 31 reads as zero.
- R5: Any word write to the fault status register stores the full value and drops irq on the next edge, unless a capture arrives in the same cycle.
- R6: Bus writes to fault address 0 and 1 (indices 4 and 5) are ignored.
- R7: After power-on reset the registers hold these values: enable = variant number in bits 31:28 with all other bits zero; delay = 0x00000020; fault address 0 = 0x07C00000; everything else 0; irq low.
- R8: Soft reset (rstN low at an edge) keeps only enable bit 8 in variant 0. In the other variants it keeps enable bits 31:24, 11 and 9:2. All other registers take their R7 values and irq drops.
- R9: Only variant 0 has the diagnostic window (busDiag = 1). It holds four bytes, takes byte-size accesses only, and selects the byte with address bits 1:0. Reads return the byte zero-extended. In other variants, and for other sizes, the window reads zero and ignores writes.
- R10: Event counters 0 and 1 are separate registers. An access to index 7 or 8 touches only its own register.
- R11: A capture pulse loads fault status from errStatus and the two fault address registers from errAddr0 and errAddr1. A capture with errStatus bit 3 set (uncorrectable) always raises irq. A correctable capture raises irq only when enable bits 0 and 1 are both set. A capture wins over a same-cycle bus write.
- R12: If fault status bit 0 or bit 3 is already set when a capture arrives, the loaded status also has bit 16 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porN | input | 1 | Asynchronous power-on reset, active low |
| rstN | input | 1 | Synchronous soft reset, active low |
| busSel | input | 1 | Access request this cycle |
| busDiag | input | 1 | 1 selects the diagnostic byte window, 0 the register window |
| busWr | input | 1 | 1 write, 0 read |
| busSize | input | 2 | Access size: 0 byte, 1 half, 2 word |
| busAddr | input | ADDR_W | Byte address inside the selected window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, registered |
| errValid | input | 1 | One-cycle fault capture pulse |
| errStatus | input | 32 | Fault status to latch |
| errAddr0 | input | 32 | Fault address word 0 to latch |
| errAddr1 | input | 32 | Fault address word 1 to latch |
| irq | output | 1 | Level interrupt |

## Verification
A write takes effect at the rising edge that samples the request. A read result is registered at that same edge and holds until the next read. A capture pulse, or a fault status write, moves irq at the edge where it is sampled. The bench therefore applies every stimulus at a falling edge and reads busRdata and irq at the following falling edge, exactly one rising edge later. Three instances, one per variant, share the stimulus, and each output is compared with a per-variant model that the bench updates as each stimulus is applied.

// File: rtl/mc_csr_pkg.sv
package mc_csr_pkg;

  localparam int DATA_W     = 32;
  localparam int IDX_W      = 4;
  localparam int NUM_REGS   = 9;
  localparam int DIAG_BYTES = 4;
  localparam int DIAG_SEL_W = $clog2(DIAG_BYTES);

  // Register indices (word address).
  localparam logic [IDX_W-1:0] IDX_EN    = 4'd0;
  localparam logic [IDX_W-1:0] IDX_DLY   = 4'd1;
  localparam logic [IDX_W-1:0] IDX_FSTAT = 4'd2;
  localparam logic [IDX_W-1:0] IDX_VID   = 4'd3;
  localparam logic [IDX_W-1:0] IDX_FADR0 = 4'd4;
  localparam logic [IDX_W-1:0] IDX_FADR1 = 4'd5;
  localparam logic [IDX_W-1:0] IDX_DIAG  = 4'd6;
  localparam logic [IDX_W-1:0] IDX_EVT0  = 4'd7;
  localparam logic [IDX_W-1:0] IDX_EVT1  = 4'd8;

  // Access size codes.
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  // Fixed masks and reset values.
  localparam logic [DATA_W-1:0] DLY_WMASK = 32'h7FFF_FFFF;
  localparam logic [DATA_W-1:0] DLY_RST   = 32'h0000_0020;
  localparam logic [DATA_W-1:0] FADR0_RST = 32'h07C0_0000;
  localparam int                FS_CORR   = 0;
  localparam int                FS_UNCORR = 3;
  localparam int                FS_MULTI  = 16;

  // Strobes from control to datapath.
  typedef struct packed {
    logic                  regWr;
    logic                  regRd;
    logic                  anyRd;
    logic [IDX_W-1:0]      idx;
    logic                  diagWr;
    logic                  diagRd;
    logic [DIAG_SEL_W-1:0] diagByte;
    logic                  capture;
    logic                  irqSet;
    logic                  irqClr;
    logic                  softRst;
  } csrStrobe_t;

  function automatic logic [DATA_W-1:0] enWriteMask(input int variant);
    return (variant == 0) ? 32'h0000_0103 : 32'h0000_0BFF;
  endfunction

  function automatic logic [DATA_W-1:0] enIdBits(input int variant);
    logic [3:0] code;
    code = 4'(variant);
    return (variant == 0) ? '0 : {code, 28'h0};
  endfunction

  function automatic logic [DATA_W-1:0] enKeepMask(input int variant);
    return (variant == 0) ? 32'h0000_0100 : 32'hFF00_0BFC;
  endfunction

  function automatic logic [DATA_W-1:0] enPorValue(input int variant);
    logic [3:0] code;
    code = 4'(variant);
    return {code, 28'h0};
  endfunction

endpackage

// File: rtl/mc_csr_ctrl.sv
module mc_csr_ctrl
  import mc_csr_pkg::*;
#(
  parameter int VARIANT = 1,
  parameter int ADDR_W  = 6
) (
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busDiag,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              errValid,
  input  logic              errUncorr,
  input  logic [1:0]        enGate,
  output csrStrobe_t        stb
);

  localparam int HI_W = ADDR_W - 2;

  logic            mainHit;
  logic            diagHit;
  logic [HI_W-1:0] wordIdx;
  logic            idxInRange;

  assign wordIdx    = busAddr[ADDR_W-1:2];
  assign mainHit    = busSel && !busDiag && (busSize == SZ_WORD);
  assign idxInRange = (wordIdx < HI_W'(NUM_REGS));

  generate
    if (VARIANT == 0) begin : g_diagDecode
      assign diagHit = busSel && busDiag && (busSize == SZ_BYTE);
    end else begin : g_noDiagDecode
      assign diagHit = 1'b0;
    end
  endgenerate

  always_comb begin
    stb          = '0;
    stb.softRst  = !rstN;
    stb.idx      = idxInRange ? IDX_W'(wordIdx) : IDX_W'(NUM_REGS);
    stb.regWr    = mainHit && busWr && idxInRange;
    stb.regRd    = mainHit && !busWr && idxInRange;
    stb.anyRd    = busSel && !busWr;
    stb.diagWr   = diagHit && busWr;
    stb.diagRd   = diagHit && !busWr;
    stb.diagByte = busAddr[DIAG_SEL_W-1:0];
    stb.capture  = errValid;
    stb.irqSet   = errValid && (errUncorr || (&enGate));
    stb.irqClr   = stb.regWr && (stb.idx == IDX_FSTAT);
  end

endmodule

// File: rtl/mc_csr_dp.sv
module mc_csr_dp
  import mc_csr_pkg::*;
#(
  parameter int VARIANT = 1
) (
  input  logic              clk,
  input  logic              porN,
  input  csrStrobe_t        stb,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] errStatus,
  input  logic [DATA_W-1:0] errAddr0,
  input  logic [DATA_W-1:0] errAddr1,
  output logic [DATA_W-1:0] rdata,
  output logic              irq,
  output logic [1:0]        enGate
);

  localparam logic [DATA_W-1:0] EN_WMASK = enWriteMask(VARIANT);
  localparam logic [DATA_W-1:0] EN_ID    = enIdBits(VARIANT);
  localparam logic [DATA_W-1:0] EN_KEEP  = enKeepMask(VARIANT);
  localparam logic [DATA_W-1:0] EN_POR   = enPorValue(VARIANT);

  logic [DATA_W-1:0] enReg, dlyReg, fstatReg, vidReg;
  logic [DATA_W-1:0] fadr0Reg, fadr1Reg, diagReg, evt0Reg, evt1Reg;
  logic [DATA_W-1:0] regQ, rdNext, fstatCapt;
  logic [7:0]        diagByteQ;
  logic              priorFault;

  assign enGate     = enReg[1:0];
  assign priorFault = fstatReg[FS_CORR] | fstatReg[FS_UNCORR];

  always_comb begin
    fstatCapt = errStatus;
    if (priorFault) fstatCapt[FS_MULTI] = 1'b1;
  end

  always_comb begin
    unique case (stb.idx)
      IDX_EN:    regQ = enReg;
      IDX_DLY:   regQ = dlyReg;
      IDX_FSTAT: regQ = fstatReg;
      IDX_VID:   regQ = vidReg;
      IDX_FADR0: regQ = fadr0Reg;
      IDX_FADR1: regQ = fadr1Reg;
      IDX_DIAG:  regQ = diagReg;
      IDX_EVT0:  regQ = evt0Reg;
      IDX_EVT1:  regQ = evt1Reg;
      default:   regQ = '0;
    endcase
  end

  always_comb begin
    if (stb.regRd)       rdNext = regQ;
    else if (stb.diagRd) rdNext = {{(DATA_W-8){1'b0}}, diagByteQ};
    else                 rdNext = '0;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      enReg    <= EN_POR;
      dlyReg   <= DLY_RST;
      fstatReg <= '0;
      vidReg   <= '0;
      fadr0Reg <= FADR0_RST;
      fadr1Reg <= '0;
      diagReg  <= '0;
      evt0Reg  <= '0;
      evt1Reg  <= '0;
      irq      <= 1'b0;
      rdata    <= '0;
    end else if (stb.softRst) begin
      enReg    <= enReg & EN_KEEP;
      dlyReg   <= DLY_RST;
      fstatReg <= '0;
      vidReg   <= '0;
      fadr0Reg <= FADR0_RST;
      fadr1Reg <= '0;
      diagReg  <= '0;
      evt0Reg  <= '0;
      evt1Reg  <= '0;
      irq      <= 1'b0;
      rdata    <= '0;
    end else begin
      if (stb.regWr) begin
        unique case (stb.idx)
          IDX_EN:    enReg    <= EN_ID | (wdata & EN_WMASK);
          IDX_DLY:   dlyReg   <= wdata & DLY_WMASK;
          IDX_FSTAT: fstatReg <= wdata;
          IDX_VID:   vidReg   <= wdata;
          IDX_DIAG:  diagReg  <= wdata;
          IDX_EVT0:  evt0Reg  <= wdata;
          IDX_EVT1:  evt1Reg  <= wdata;
          default:   ;
        endcase
      end
      if (stb.capture) begin
        fstatReg <= fstatCapt;
        fadr0Reg <= errAddr0;
        fadr1Reg <= errAddr1;
      end
      if (stb.irqSet)      irq <= 1'b1;
      else if (stb.irqClr) irq <= 1'b0;
      if (stb.anyRd) rdata <= rdNext;
    end
  end

  generate
    if (VARIANT == 0) begin : g_diagWin
      logic [7:0] diagMem [DIAG_BYTES];
      always_ff @(posedge clk or negedge porN) begin
        if (!porN) begin
          for (int i = 0; i < DIAG_BYTES; i++) diagMem[i] <= '0;
        end else if (stb.diagWr) begin
          diagMem[stb.diagByte] <= wdata[7:0];
        end
      end
      assign diagByteQ = diagMem[stb.diagByte];
    end else begin : g_noDiagWin
      logic unusedDiag;
      assign unusedDiag = stb.diagWr;
      assign diagByteQ  = '0;
    end
  endgenerate

endmodule

// File: rtl/mc_csr_top.sv
module mc_csr_top
  import mc_csr_pkg::*;
#(
  parameter int VARIANT = 1,
  parameter int ADDR_W  = 6
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busDiag,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              errValid,
  input  logic [31:0]       errStatus,
  input  logic [31:0]       errAddr0,
  input  logic [31:0]       errAddr1,
  output logic              irq
);

  csrStrobe_t stb;
  logic [1:0] enGate;

  mc_csr_ctrl #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_ctrl (
    .rstN      (rstN),
    .busSel    (busSel),
    .busDiag   (busDiag),
    .busWr     (busWr),
    .busSize   (busSize),
    .busAddr   (busAddr),
    .errValid  (errValid),
    .errUncorr (errStatus[FS_UNCORR]),
    .enGate    (enGate),
    .stb       (stb)
  );

  mc_csr_dp #(.VARIANT(VARIANT)) u_dp (
    .clk       (clk),
    .porN      (porN),
    .stb       (stb),
    .wdata     (busWdata),
    .errStatus (errStatus),
    .errAddr0  (errAddr0),
    .errAddr1  (errAddr1),
    .rdata     (busRdata),
    .irq       (irq),
    .enGate    (enGate)
  );

endmodule

// File: rtl/mc_csr_chk.sv
module mc_csr_chk #(
  parameter int VARIANT = 1,
  parameter int ADDR_W  = 6
) (
  input logic              clk,
  input logic              porN,
  input logic              rstN,
  input logic              busSel,
  input logic              busDiag,
  input logic              busWr,
  input logic [1:0]        busSize,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdata,
  input logic              errValid,
  input logic [31:0]       errStatus,
  input logic              irq
);

  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] idx;
  logic            wordRd, wordWr, otherRd, diagRd;

  assign idx     = busAddr[ADDR_W-1:2];
  assign wordRd  = busSel && !busDiag && !busWr && (busSize == 2'd2);
  assign wordWr  = busSel && !busDiag && busWr && (busSize == 2'd2);
  assign otherRd = busSel && !busDiag && !busWr && (busSize != 2'd2);
  assign diagRd  = busSel && busDiag && !busWr;

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (wordRd && idx >= HI_W'(9)) |=> (busRdata == 32'h0)); // R1

  AST_SUBWORD_ZERO: assert property (@(posedge clk) disable iff (!porN || !rstN)
    otherRd |=> (busRdata == 32'h0)); // R2

  AST_DLY_TOPBIT: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (wordRd && idx == HI_W'(1)) |=> !busRdata[31]); // R4

  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (wordWr && idx == HI_W'(2) && !errValid) |=> !irq); // R5

  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (irq && !errValid && !(wordWr && idx == HI_W'(2))) |=> irq); // R5

  AST_UNCORR_IRQ: assert property (@(posedge clk) disable iff (!porN || !rstN)
    (errValid && errStatus[3]) |=> irq); // R11

  generate
    if (VARIANT != 0) begin : g_idChecks
      AST_EN_IDCODE: assert property (@(posedge clk) disable iff (!porN || !rstN)
        (wordRd && idx == HI_W'(0)) |=> (busRdata[31:28] == 4'(VARIANT))); // R3

      AST_NO_DIAG: assert property (@(posedge clk) disable iff (!porN || !rstN)
        diagRd |=> (busRdata == 32'h0)); // R9
    end else begin : g_diagChecks
      AST_DIAG_BYTEWIDE: assert property (@(posedge clk) disable iff (!porN || !rstN)
        diagRd |=> (busRdata[31:8] == 24'h0)); // R9
    end
  endgenerate

endmodule

bind mc_csr_top mc_csr_chk #(.VARIANT(VARIANT), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .porN      (porN),
  .rstN      (rstN),
  .busSel    (busSel),
  .busDiag   (busDiag),
  .busWr     (busWr),
  .busSize   (busSize),
  .busAddr   (busAddr),
  .busRdata  (busRdata),
  .errValid  (errValid),
  .errStatus (errStatus),
  .irq       (irq)
);

// File: tb/mc_csr_top_test.sv
module mc_csr_top_test;

  localparam int ADDR_W = 6;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              porN, rstN, busSel, busDiag, busWr, errValid;
  logic [1:0]        busSize;
  logic [ADDR_W-1:0] busAddr;
  logic [31:0]       busWdata, errStatus, errAddr0, errAddr1;
  logic [31:0]       rdV0, rdV1, rdV2;
  logic              irqV0, irqV1, irqV2;

  mc_csr_top #(.VARIANT(0), .ADDR_W(ADDR_W)) uutV0 (
    .clk(clk), .porN(porN), .rstN(rstN), .busSel(busSel), .busDiag(busDiag),
    .busWr(busWr), .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rdV0), .errValid(errValid), .errStatus(errStatus),
    .errAddr0(errAddr0), .errAddr1(errAddr1), .irq(irqV0));

  mc_csr_top #(.VARIANT(1), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .porN(porN), .rstN(rstN), .busSel(busSel), .busDiag(busDiag),
    .busWr(busWr), .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rdV1), .errValid(errValid), .errStatus(errStatus),
    .errAddr0(errAddr0), .errAddr1(errAddr1), .irq(irqV1));

  mc_csr_top #(.VARIANT(2), .ADDR_W(ADDR_W)) uutV2 (
    .clk(clk), .porN(porN), .rstN(rstN), .busSel(busSel), .busDiag(busDiag),
    .busWr(busWr), .busSize(busSize), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(rdV2), .errValid(errValid), .errStatus(errStatus),
    .errAddr0(errAddr0), .errAddr1(errAddr1), .irq(irqV2));

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  logic [31:0] mdl [3][9];
  logic [7:0]  mdiag [4];
  logic        mirq [3];

  function automatic logic [31:0] rdOf(input int v);
    return (v == 0) ? rdV0 : (v == 1) ? rdV1 : rdV2;
  endfunction

  function automatic logic irqOf(input int v);
    return (v == 0) ? irqV0 : (v == 1) ? irqV1 : irqV2;
  endfunction

  function automatic string reqOf(input int idx);
    case (idx)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      4, 5: return "R6";
      7, 8: return "R10";
      default: return "R1";
    endcase
  endfunction

  task automatic check(input string req, input int v, input logic [31:0] act,
                       input logic [31:0] exp, input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s variant%0d %s actual=%h expected=%h", req, v, what, act, exp);
    end
  endtask

  task automatic porModel();
    for (int v = 0; v < 3; v++) begin
      for (int i = 0; i < 9; i++) mdl[v][i] = 32'h0;
      mdl[v][0] = 32'(v) << 28;
      mdl[v][1] = 32'h20;
      mdl[v][4] = 32'h07C0_0000;
      mirq[v]   = 1'b0;
    end
    for (int b = 0; b < 4; b++) mdiag[b] = 8'h0;
  endtask

  task automatic modelWrite(input int idx, input logic [31:0] d);
    for (int v = 0; v < 3; v++) begin
      case (idx)
        0: mdl[v][0] = (v == 0) ? (d & 32'h103) : ((32'(v) << 28) | (d & 32'hBFF));
        1: mdl[v][1] = d & 32'h7FFF_FFFF;
        2: begin mdl[v][2] = d; mirq[v] = 1'b0; end
        3, 6, 7, 8: mdl[v][idx] = d;
        default: ;
      endcase
    end
  endtask

  task automatic doWrite(input int addr, input logic [31:0] d,
                         input logic [1:0] sz, input logic diag);
    @(negedge clk);
    busSel = 1; busWr = 1; busDiag = diag; busSize = sz;
    busAddr = ADDR_W'(addr); busWdata = d;
    @(negedge clk);
    busSel = 0; busWr = 0; busDiag = 0;
    if (!diag && sz == 2'd2) modelWrite(addr >> 2, d);
    if (diag && sz == 2'd0) mdiag[addr % 4] = d[7:0];
  endtask

  task automatic readCheck(input int addr, input logic [1:0] sz,
                           input logic diag, input string req);
    logic [31:0] exp;
    @(negedge clk);
    busSel = 1; busWr = 0; busDiag = diag; busSize = sz;
    busAddr = ADDR_W'(addr);
    @(negedge clk);
    busSel = 0; busDiag = 0;
    for (int v = 0; v < 3; v++) begin
      if (!diag && sz == 2'd2 && (addr >> 2) < 9) exp = mdl[v][addr >> 2];
      else if (diag && sz == 2'd0 && v == 0) exp = {24'h0, mdiag[addr % 4]};
      else exp = 32'h0;
      check(req, v, rdOf(v), exp, $sformatf("read addr=%0d size=%0d diag=%0d", addr, sz, diag));
    end
  endtask

  task automatic readAll();
    for (int i = 0; i < 16; i++) readCheck(i * 4, 2'd2, 1'b0, reqOf(i));
  endtask

  task automatic irqCheck(input string req);
    for (int v = 0; v < 3; v++)
      check(req, v, {31'h0, irqOf(v)}, {31'h0, mirq[v]}, "irq");
  endtask

  task automatic capture(input logic [31:0] st, input logic [31:0] a0, input logic [31:0] a1);
    @(negedge clk);
    errValid = 1; errStatus = st; errAddr0 = a0; errAddr1 = a1;
    @(negedge clk);
    errValid = 0;
    for (int v = 0; v < 3; v++) begin
      logic multi;
      multi = mdl[v][2][0] | mdl[v][2][3];
      mdl[v][2] = st | (multi ? 32'h0001_0000 : 32'h0);
      mdl[v][4] = a0;
      mdl[v][5] = a1;
      if (st[3] || (mdl[v][0][0] && mdl[v][0][1])) mirq[v] = 1'b1;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'hFFFF_FFFF; pats[1] = 32'hA5A5_A5A5;
    pats[2] = 32'h5A5A_5A5A; pats[3] = 32'h0000_0000;
    porN = 0; rstN = 1; busSel = 0; busDiag = 0; busWr = 0; busSize = 2'd2;
    busAddr = '0; busWdata = '0; errValid = 0; errStatus = '0; errAddr0 = '0; errAddr1 = '0;
    porModel();
    repeat (3) @(negedge clk);
    porN = 1;

    // R7: power-on values
    for (int i = 0; i < 9; i++) readCheck(i * 4, 2'd2, 1'b0, "R7");
    irqCheck("R7");

    // R1 R3 R4 R5 R6 R10: sweep every index with several patterns
    foreach (pats[p]) begin
      for (int i = 0; i < 16; i++) doWrite(i * 4, pats[p] ^ (32'(i) * 32'h0101_0101), 2'd2, 1'b0);
      readAll();
    end

    // R10: independent event counters
    doWrite(7 * 4, 32'h1111_1111, 2'd2, 1'b0);
    doWrite(8 * 4, 32'h2222_2222, 2'd2, 1'b0);
    readCheck(7 * 4, 2'd2, 1'b0, "R10");
    readCheck(8 * 4, 2'd2, 1'b0, "R10");

    // R2: non-word accesses to the register window
    for (int s = 0; s < 4; s++) begin
      if (s != 2) begin
        doWrite(3 * 4, 32'hDEAD_0000 | 32'(s), 2'(s), 1'b0);
        readCheck(3 * 4, 2'(s), 1'b0, "R2");
      end
    end
    readCheck(3 * 4, 2'd2, 1'b0, "R2");

    // R9: diagnostic byte window, address wraps modulo four
    for (int a = 0; a < 8; a++) doWrite(a, 32'(a * 31 + 3), 2'd0, 1'b1);
    for (int a = 0; a < 4; a++) readCheck(a, 2'd0, 1'b1, "R9");
    doWrite(1, 32'hFFFF_FFFF, 2'd2, 1'b1);
    readCheck(1, 2'd0, 1'b1, "R9");
    readCheck(1, 2'd2, 1'b1, "R9");

    // R11: correctable capture gated by enable bits 0 and 1
    doWrite(0, 32'h0, 2'd2, 1'b0);
    doWrite(2 * 4, 32'h0, 2'd2, 1'b0);
    capture(32'h0000_0A01, 32'h1234_5678, 32'h9ABC_DEF0);
    irqCheck("R11");
    readCheck(2 * 4, 2'd2, 1'b0, "R11");
    readCheck(4 * 4, 2'd2, 1'b0, "R11");
    readCheck(5 * 4, 2'd2, 1'b0, "R11");
    doWrite(2 * 4, 32'h0, 2'd2, 1'b0);
    capture(32'h0000_0008, 32'h0000_0042, 32'h0000_0043);
    irqCheck("R11");
    doWrite(2 * 4, 32'h0, 2'd2, 1'b0);
    irqCheck("R5");
    doWrite(0, 32'h0000_0003, 2'd2, 1'b0);
    capture(32'h0000_0001, 32'hAAAA_0000, 32'h5555_0000);
    irqCheck("R11");
    readCheck(2 * 4, 2'd2, 1'b0, "R11");

    // R12: second fault while status still set
    capture(32'h0000_0001, 32'hAAAA_1111, 32'h5555_2222);
    readCheck(2 * 4, 2'd2, 1'b0, "R12");
    capture(32'h0000_0008, 32'h0, 32'h0);
    readCheck(2 * 4, 2'd2, 1'b0, "R12");
    doWrite(2 * 4, 32'h0, 2'd2, 1'b0);
    irqCheck("R5");
    capture(32'h0000_0008, 32'h1, 32'h2);
    readCheck(2 * 4, 2'd2, 1'b0, "R12");

    // R8: soft reset keeps selected enable fields
    for (int i = 0; i < 9; i++) doWrite(i * 4, 32'hFFFF_FFFF, 2'd2, 1'b0);
    capture(32'h0000_0008, 32'h7, 32'h8);
    @(negedge clk);
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    for (int v = 0; v < 3; v++) begin
      logic [31:0] keepEn;
      keepEn = mdl[v][0] & ((v == 0) ? 32'h0000_0100 : 32'hFF00_0BFC);
      for (int i = 0; i < 9; i++) mdl[v][i] = 32'h0;
      mdl[v][0] = keepEn;
      mdl[v][1] = 32'h20;
      mdl[v][4] = 32'h07C0_0000;
      mirq[v]   = 1'b0;
    end
    for (int i = 0; i < 9; i++) readCheck(i * 4, 2'd2, 1'b0, "R8");
    irqCheck("R8");

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule